// File: doc/BRIEF.md
# Mixed-Policy Data Cache Controller

This block is the tag and policy side of a set-associative first-level data cache for a throughput processor. Each cycle it can accept one request, which carries an address, a store flag, an access class (global or local) and a byte size. The class decides the write policy.

- A global store that hits is sent downstream unchanged as a write-through, and the line it hit is dropped.
- A local store that hits stays in the cache and marks the line dirty.
- A store that misses goes downstream without taking a line.
- A load that misses asks for a whole line. If the line it replaces is dirty, a line-sized writeback of that line is queued just after the read.

All downstream traffic leaves through one bounded miss queue with a valid/ready output. A request is accepted only when the queue can take every entry that request might need. Otherwise it is refused with a reservation failure and changes nothing. One cycle after each request the block reports the outcome and which kinds of downstream traffic the request caused. It also raises an error flag when a global store hits a dirty line, which a correct program never does. The returned fill data is not handled here: a load miss installs its tag as valid at once.

Top module: `dcc_top`

## Requirements
- R1: A local store (class 1) that hits returns HIT (status code 0), marks the line dirty and makes that way most recently used; it pushes nothing to the miss queue and raises no event.
- R2: A global store (class 0) that hits, with the queue below capacity, returns HIT with the write event. It pushes the request's own address and size with kind WRITE (kind code 1) and invalidates the line, so a later load of that address misses.
- R3: A global store that hits while the miss queue holds its full depth of entries returns RESERVATION-FAIL (status code 2), raises no event and changes no state.
- R4: A store of either class that misses returns MISS (status code 1) with the write event and pushes itself as kind WRITE without allocating a line; with the queue full it returns RESERVATION-FAIL instead.
- R5: A load that misses is refused with RESERVATION-FAIL whenever queue occupancy plus one is not below the queue depth, whether or not the victim is dirty.
- R6: An accepted load miss returns MISS with the read event and pushes kind READ (code 0) with the line-aligned address and the line size in bytes. It installs its tag in the victim way as valid and clean, and makes that way most recently used.
- R7: When the victim of an accepted load miss is valid and dirty, a second entry of kind WRITEBACK (code 2) follows the read in the same cycle, carrying the victim's line address and the line size, and the writeback event is raised; a writeback is never issued without a load miss.
- R8: A load that hits returns HIT, raises no event, pushes nothing and makes the hit way most recently used.
- R9: The victim is the lowest-numbered invalid way of the set, or, when all ways are valid, the least recently used way (true LRU over loads and stores that hit or allocate).
- R10: A global store that hits a dirty line raises the error flag together with its response, and still performs the write-through and the invalidation.
- R11: The miss queue delivers entries in push order, holds its head while ready is low, drops valid only when empty, and never holds more than its depth.
- R12: Responses are registered: the response valid and its fields appear in the cycle after the request, and a cycle without a request gives response valid low and all event and error flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_local | input | 1 | Access class: 1 = local, 0 = global |
| req_size | input | SIZE_W | Request size in bytes |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_status | output | 2 | 0 = HIT, 1 = MISS, 2 = RESERVATION-FAIL |
| evt_read_sent | output | 1 | A line read was queued |
| evt_write_sent | output | 1 | A store was forwarded downstream |
| evt_wback_sent | output | 1 | A dirty-victim writeback was queued |
| err_global_dirty | output | 1 | Global store hit a dirty line |
| mq_valid | output | 1 | Miss queue head is valid |
| mq_ready | input | 1 | Downstream takes the head this cycle |
| mq_addr | output | ADDR_W | Head address |
| mq_kind | output | 2 | 0 = READ, 1 = WRITE, 2 = WRITEBACK |
| mq_size | output | SIZE_W | Head size in bytes |

## Verification
The assertions check on every cycle the rules that need no memory of the cache's contents. A writeback appears only beside a read. A refused or absent request is silent. A hit never reports a read. The error flag comes only with a write-through hit. The queue never exceeds its depth and holds its head under back-pressure. Which way a miss replaces, whether a store allocated, whether an invalidated or dirtied line behaves as such later, and the exact queue contents and thresholds depend on history, so only the bench's reference model and its directed sequences show them.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    ST_HIT   = 2'd0,
    ST_MISS  = 2'd1,
    ST_RFAIL = 2'd2
  } dcc_status_e;

  typedef enum logic [1:0] {
    MQ_READ  = 2'd0,
    MQ_WRITE = 2'd1,
    MQ_WBACK = 2'd2
  } mq_kind_e;
endpackage

// File: rtl/dcc_way_match.sv
module dcc_way_match #(
  parameter int TAG_W = 25,
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            valid,
  input  logic [TAG_W-1:0]           probe,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  logic [WAYS-1:0] eq;

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign eq[g] = valid[g] && (tags[g] == probe);
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (eq[i] && !hit) begin
        hit = 1'b1;
        way = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/dcc_lru.sv
module dcc_lru #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0] ages,
  input  logic [WAYS-1:0]            valid,
  input  logic [WAY_W-1:0]           touch_way,
  output logic [WAY_W-1:0]           victim,
  output logic [WAYS-1:0][WAY_W-1:0] ages_next
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!valid[i] && !found) begin
        victim = WAY_W'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < WAYS; i++) begin
        if (ages[i] == OLDEST) victim = WAY_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == touch_way)
        ages_next[i] = '0;
      else if (ages[i] < ages[touch_way])
        ages_next[i] = ages[i] + 1'b1;
      else
        ages_next[i] = ages[i];
    end
  end
endmodule

// File: rtl/dcc_miss_fifo.sv
module dcc_miss_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 42,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push0,
  input  logic [W-1:0]     din0,
  input  logic             push1,
  input  logic [W-1:0]     din1,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             not_empty,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push0) mem[wptr] <= din0;
    if (push0 && push1) mem[inc(wptr)] <= din1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push0 && push1) wptr <= inc(inc(wptr));
      else if (push0)     wptr <= inc(wptr);
      if (pop) rptr <= inc(rptr);
      count <= count + CNT_W'(push0) + CNT_W'(push0 && push1) - CNT_W'(pop);
    end
  end

  assign dout      = mem[rptr];
  assign not_empty = (count != '0);
endmodule

// File: rtl/dcc_top.sv
module dcc_top import dcc_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 4,
  parameter int WAYS       = 4,
  parameter int MQ_DEPTH   = 4,
  parameter int SIZE_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_local,
  input  logic [SIZE_W-1:0] req_size,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic              evt_read_sent,
  output logic              evt_write_sent,
  output logic              evt_wback_sent,
  output logic              err_global_dirty,
  output logic              mq_valid,
  input  logic              mq_ready,
  output logic [ADDR_W-1:0] mq_addr,
  output logic [1:0]        mq_kind,
  output logic [SIZE_W-1:0] mq_size
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int CNT_W = $clog2(MQ_DEPTH + 1);
  localparam int ENT_W = ADDR_W + 2 + SIZE_W;
  localparam logic [CNT_W:0]    DEPTH_X   = (CNT_W + 1)'(MQ_DEPTH);
  localparam logic [SIZE_W-1:0] LINE_SIZE = SIZE_W'(LINE_BYTES);

  // Tag state
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            vld_q   [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0] age_q   [SETS];

  logic [IDX_W-1:0]  s_idx;
  logic [TAG_W-1:0]  s_tag;
  logic [ADDR_W-1:0] line_addr;
  logic              hit;
  logic [WAY_W-1:0]  hit_way, victim, touch_way;
  logic [WAYS-1:0][WAY_W-1:0] ages_next;

  assign s_idx     = req_addr[OFF_W +: IDX_W];
  assign s_tag     = req_addr[ADDR_W-1 -: TAG_W];
  assign line_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  dcc_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
    .tags  (tag_q[s_idx]),
    .valid (vld_q[s_idx]),
    .probe (s_tag),
    .hit   (hit),
    .way   (hit_way)
  );

  assign touch_way = hit ? hit_way : victim;

  dcc_lru #(.WAYS(WAYS)) u_lru (
    .ages      (age_q[s_idx]),
    .valid     (vld_q[s_idx]),
    .touch_way (touch_way),
    .victim    (victim),
    .ages_next (ages_next)
  );

  // Miss queue
  logic             push0, push1, mq_pop;
  logic [ENT_W-1:0] ent0, ent1, mq_ent;
  logic [CNT_W-1:0] mq_count;
  logic [CNT_W:0]   cnt_x;

  assign mq_pop = mq_valid && mq_ready;
  assign cnt_x  = {1'b0, mq_count};

  dcc_miss_fifo #(.DEPTH(MQ_DEPTH), .W(ENT_W)) u_mq (
    .clk       (clk),
    .rst       (rst),
    .push0     (push0),
    .din0      (ent0),
    .push1     (push1),
    .din1      (ent1),
    .pop       (mq_pop),
    .dout      (mq_ent),
    .not_empty (mq_valid),
    .count     (mq_count)
  );

  assign {mq_addr, mq_kind, mq_size} = mq_ent;

  // Policy decision
  dcc_status_e st_d;
  logic evr_d, evw_d, evwb_d, err_d;
  logic act_touch, act_dirty, act_inval, act_install;

  always_comb begin
    st_d        = ST_HIT;
    evr_d       = 1'b0;
    evw_d       = 1'b0;
    evwb_d      = 1'b0;
    err_d       = 1'b0;
    push0       = 1'b0;
    push1       = 1'b0;
    ent0        = {req_addr, MQ_WRITE, req_size};
    ent1        = {tag_q[s_idx][victim], s_idx, {OFF_W{1'b0}}, MQ_WBACK, LINE_SIZE};
    act_touch   = 1'b0;
    act_dirty   = 1'b0;
    act_inval   = 1'b0;
    act_install = 1'b0;
    if (req_valid) begin
      if (req_write) begin
        if (hit && !req_local) begin
          if (cnt_x >= DEPTH_X) begin
            st_d = ST_RFAIL;
          end else begin
            push0     = 1'b1;
            evw_d     = 1'b1;
            act_inval = 1'b1;
            err_d     = dirty_q[s_idx][hit_way];
          end
        end else if (hit) begin
          act_touch = 1'b1;
          act_dirty = 1'b1;
        end else if (cnt_x >= DEPTH_X) begin
          st_d = ST_RFAIL;
        end else begin
          st_d  = ST_MISS;
          push0 = 1'b1;
          evw_d = 1'b1;
        end
      end else begin
        if (hit) begin
          act_touch = 1'b1;
        end else if (cnt_x + 1'b1 >= DEPTH_X) begin
          st_d = ST_RFAIL;
        end else begin
          st_d        = ST_MISS;
          ent0        = {line_addr, MQ_READ, LINE_SIZE};
          push0       = 1'b1;
          evr_d       = 1'b1;
          act_touch   = 1'b1;
          act_install = 1'b1;
          if (vld_q[s_idx][victim] && dirty_q[s_idx][victim]) begin
            push1  = 1'b1;
            evwb_d = 1'b1;
          end
        end
      end
    end
  end

  // State update
  always_ff @(posedge clk) begin
    if (act_install) tag_q[s_idx][victim] <= s_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]   <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      if (act_touch) age_q[s_idx] <= ages_next;
      if (act_dirty) dirty_q[s_idx][hit_way] <= 1'b1;
      if (act_inval) vld_q[s_idx][hit_way] <= 1'b0;
      if (act_install) begin
        vld_q[s_idx][victim]   <= 1'b1;
        dirty_q[s_idx][victim] <= 1'b0;
      end
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid        <= 1'b0;
      rsp_status       <= ST_HIT;
      evt_read_sent    <= 1'b0;
      evt_write_sent   <= 1'b0;
      evt_wback_sent   <= 1'b0;
      err_global_dirty <= 1'b0;
    end else begin
      rsp_valid        <= req_valid;
      rsp_status       <= st_d;
      evt_read_sent    <= evr_d;
      evt_write_sent   <= evw_d;
      evt_wback_sent   <= evwb_d;
      err_global_dirty <= err_d;
    end
  end
endmodule

// File: rtl/dcc_top_chk.sv
module dcc_top_chk #(
  parameter int ADDR_W   = 32,
  parameter int MQ_DEPTH = 4,
  parameter int CNT_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic              evt_read_sent,
  input logic              evt_write_sent,
  input logic              evt_wback_sent,
  input logic              err_global_dirty,
  input logic              mq_valid,
  input logic              mq_ready,
  input logic [ADDR_W-1:0] mq_addr,
  input logic [CNT_W-1:0]  mq_count
);
  p_wb_with_read_r7: assert property (@(posedge clk) disable iff (rst)
    evt_wback_sent |-> (rsp_valid && evt_read_sent && rsp_status == 2'd1));

  p_rfail_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd2) |->
      !(evt_read_sent || evt_write_sent || evt_wback_sent || err_global_dirty));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(evt_read_sent || evt_write_sent || evt_wback_sent || err_global_dirty));

  p_hit_no_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd0) |-> !(evt_read_sent || evt_wback_sent));

  p_err_with_write_r10: assert property (@(posedge clk) disable iff (rst)
    err_global_dirty |-> (evt_write_sent && rsp_status == 2'd0));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    (int'(mq_count) <= MQ_DEPTH) && (mq_valid == (mq_count != '0)));

  p_head_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mq_valid && !mq_ready) |=> (mq_valid && $stable(mq_addr)));
endmodule

bind dcc_top dcc_top_chk #(.ADDR_W(ADDR_W), .MQ_DEPTH(MQ_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .rsp_valid        (rsp_valid),
  .rsp_status       (rsp_status),
  .evt_read_sent    (evt_read_sent),
  .evt_write_sent   (evt_write_sent),
  .evt_wback_sent   (evt_wback_sent),
  .err_global_dirty (err_global_dirty),
  .mq_valid         (mq_valid),
  .mq_ready         (mq_ready),
  .mq_addr          (mq_addr),
  .mq_count         (mq_count)
);

// File: tb/dcc_top_tb.sv
`timescale 1ns/1ps
module dcc_top_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_local, mq_ready;
  logic [31:0] req_addr;
  logic [7:0]  req_size;
  logic        rsp_valid, evt_read_sent, evt_write_sent, evt_wback_sent, err_global_dirty;
  logic [1:0]  rsp_status, mq_kind;
  logic        mq_valid;
  logic [31:0] mq_addr;
  logic [7:0]  mq_size;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  dcc_top u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_local(req_local), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .evt_read_sent(evt_read_sent),
    .evt_write_sent(evt_write_sent), .evt_wback_sent(evt_wback_sent),
    .err_global_dirty(err_global_dirty), .mq_valid(mq_valid), .mq_ready(mq_ready),
    .mq_addr(mq_addr), .mq_kind(mq_kind), .mq_size(mq_size)
  );

  // Reference model
  logic [24:0] m_tag   [4][4];
  bit          m_vld   [4][4];
  bit          m_dirty [4][4];
  int          m_age   [4][4];
  logic [41:0] mq_model [$];

  logic [1:0] e_status;
  bit e_valid, e_r, e_w, e_wb, e_err;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_addr(input int tg, input int idx, input int off);
    return {25'(tg), 2'(idx), 5'(off)};
  endfunction

  task automatic m_touch(input int s, input int w);
    int a = m_age[s][w];
    for (int i = 0; i < 4; i++) if (m_age[s][i] < a) m_age[s][i]++;
    m_age[s][w] = 0;
  endtask

  task automatic m_reset();
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin
        m_vld[s][w] = 0; m_dirty[s][w] = 0; m_age[s][w] = w; m_tag[s][w] = '0;
      end
    mq_model.delete();
  endtask

  task automatic m_access(input bit v, input bit wr, input bit loc,
                          input logic [31:0] a, input logic [7:0] sz, input bit rdy);
    int s = int'(a[6:5]);
    logic [24:0] tg = a[31:7];
    bit hit = 0;
    int hw = 0, cnt = mq_model.size(), vic;
    logic [41:0] p [$];
    e_valid = v; e_status = 2'd0; e_r = 0; e_w = 0; e_wb = 0; e_err = 0;
    if (v) begin
      for (int w = 0; w < 4; w++)
        if (m_vld[s][w] && m_tag[s][w] == tg && !hit) begin hit = 1; hw = w; end
      if (wr) begin
        if (hit && !loc) begin
          if (cnt >= DEPTH) e_status = 2'd2;
          else begin
            p.push_back({a, 2'd1, sz}); m_vld[s][hw] = 0; e_w = 1; e_err = m_dirty[s][hw];
          end
        end else if (hit) begin
          m_touch(s, hw); m_dirty[s][hw] = 1;
        end else if (cnt >= DEPTH) e_status = 2'd2;
        else begin
          e_status = 2'd1; e_w = 1; p.push_back({a, 2'd1, sz});
        end
      end else begin
        if (hit) m_touch(s, hw);
        else if (cnt + 1 >= DEPTH) e_status = 2'd2;
        else begin
          vic = -1;
          for (int w = 0; w < 4; w++) if (!m_vld[s][w] && vic < 0) vic = w;
          if (vic < 0) for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) vic = w;
          e_status = 2'd1; e_r = 1;
          p.push_back({a[31:5], 5'd0, 2'd0, 8'd32});
          if (m_vld[s][vic] && m_dirty[s][vic]) begin
            e_wb = 1; p.push_back({m_tag[s][vic], 2'(s), 5'd0, 2'd2, 8'd32});
          end
          m_tag[s][vic] = tg; m_vld[s][vic] = 1; m_dirty[s][vic] = 0; m_touch(s, vic);
        end
      end
    end
    if (rdy && mq_model.size() > 0) void'(mq_model.pop_front());
    foreach (p[i]) mq_model.push_back(p[i]);
  endtask

  // One request cycle: starts and ends at a falling edge
  task automatic step(input bit v, input bit wr, input bit loc,
                      input logic [31:0] a, input logic [7:0] sz, input bit rdy);
    if (mq_model.size() > 0) begin
      chk("R11 mq_valid", 64'(mq_valid), 64'd1);
      chk("R11 mq head", 64'({mq_addr, mq_kind, mq_size}), 64'(mq_model[0]));
    end else
      chk("R11 mq empty", 64'(mq_valid), 64'd0);
    req_valid = v; req_write = wr; req_local = loc; req_addr = a; req_size = sz; mq_ready = rdy;
    m_access(v, wr, loc, a, sz, rdy);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R12 rsp_valid", 64'(rsp_valid), 64'(e_valid));
    if (e_valid) chk("R1-status", 64'(rsp_status), 64'(e_status));
    chk("R6 read event", 64'(evt_read_sent), 64'(e_r));
    chk("R4 write event", 64'(evt_write_sent), 64'(e_w));
    chk("R7 writeback event", 64'(evt_wback_sent), 64'(e_wb));
    chk("R10 error flag", 64'(err_global_dirty), 64'(e_err));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; req_valid = 0; req_write = 0; req_local = 0; req_addr = '0; req_size = '0; mq_ready = 1;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // Reset state (R12, R11)
    chk("R12 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11 reset mq_valid", 64'(mq_valid), 64'd0);

    // R6/R9: fill set 0 through invalid ways, then LRU
    for (int t = 1; t <= 4; t++) step(1, 0, 0, mk_addr(t, 0, 4), 8'd4, 1);
    step(1, 0, 0, mk_addr(1, 0, 8), 8'd4, 1);        // R8 load hit
    step(1, 1, 1, mk_addr(2, 0, 0), 8'd4, 1);        // R1 local store hit
    step(1, 0, 0, mk_addr(5, 0, 0), 8'd4, 1);        // R9 evicts tag 3
    step(1, 0, 0, mk_addr(6, 0, 0), 8'd4, 1);        // evicts tag 4
    step(1, 0, 0, mk_addr(7, 0, 0), 8'd4, 1);        // evicts tag 1
    step(1, 0, 0, mk_addr(8, 0, 12), 8'd4, 1);       // R7 evicts dirty tag 2
    chk("R7 writeback after dirty victim", 64'(evt_wback_sent), 64'd1);
    step(0, 0, 0, '0, '0, 1);                        // R12 idle
    // R10 / R2 on set 1
    step(1, 0, 0, mk_addr(9, 1, 0), 8'd4, 1);
    step(1, 1, 1, mk_addr(9, 1, 4), 8'd4, 1);
    step(1, 1, 0, mk_addr(9, 1, 4), 8'd4, 1);        // R10
    chk("R10 error on dirty global hit", 64'(err_global_dirty), 64'd1);
    step(1, 0, 0, mk_addr(9, 1, 4), 8'd4, 1);        // R2 line invalidated
    chk("R2 load after write-through misses", 64'(rsp_status), 64'd1);
    // R4 store miss does not allocate
    step(1, 1, 0, mk_addr(10, 2, 0), 8'd2, 1);
    step(1, 0, 0, mk_addr(10, 2, 0), 8'd4, 1);
    chk("R4 no allocate on store miss", 64'(rsp_status), 64'd1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0, '0, 1);
    // R3/R5 under back-pressure; tag 10 set 2 is resident
    for (int i = 0; i < 3; i++) step(1, 1, 1, mk_addr(20 + i, 3, 0), 8'd4, 0);
    step(1, 0, 0, mk_addr(30, 3, 0), 8'd4, 0);       // R5 count 3
    chk("R5 load miss refused", 64'(rsp_status), 64'd2);
    step(1, 1, 0, mk_addr(24, 3, 0), 8'd4, 0);       // fills queue
    step(1, 1, 0, mk_addr(10, 2, 0), 8'd4, 0);       // R3
    chk("R3 global hit refused when full", 64'(rsp_status), 64'd2);
    step(1, 1, 0, mk_addr(25, 3, 0), 8'd4, 0);       // R4 store miss full
    for (int i = 0; i < 6; i++) step(0, 0, 0, '0, '0, 1);
    step(1, 0, 0, mk_addr(10, 2, 0), 8'd4, 1);       // R3 no state change: still hit
    chk("R3 line kept after refusal", 64'(rsp_status), 64'd0);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      step(r < 85, ($urandom % 2) == 1, ($urandom % 2) == 1,
           mk_addr(int'($urandom % 6), int'($urandom % 2), int'($urandom % 32)),
           8'(1 + $urandom % 8), ($urandom % 10) < 7);
    end
    for (int i = 0; i < 10; i++) step(0, 0, 0, '0, '0, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule